// File: doc/BRIEF.md
# Six-Mode Shift and Rotate Unit

This block moves the bits of an N-bit word by an unsigned distance in one of six ways: two logical shifts, two arithmetic shifts and two rotations. A 3-bit operation code picks the way, and codes outside the six pass the word through untouched. Shift distances of zero, of exactly N and of more than N are all legal and have defined results.

The datapath is pure combinational logic. A parameter places a result register behind it. With the register in place, the result and a valid flag come out one clock after the inputs are taken. With it removed, the output follows the inputs and the valid flag is the input strobe. The word width and the width of the distance field are parameters. The bench builds the default 6-bit case, and the same source serves 16- and 32-bit words.

Top module: `shift_rotate_unit`

## Requirements
- R1: Operation code 3'b000 (logical left) moves every bit toward the MSB by the distance and fills the vacated low positions with 0.
- R2: Operation code 3'b001 (logical right) moves every bit toward the LSB by the distance and fills the vacated high positions with 0.
- R3: Operation code 3'b010 (arithmetic left) moves bits toward the MSB and fills the vacated low positions with copies of the input's bit 0. For example, 101001 by 2 gives 100111.
- R4: Operation code 3'b011 (arithmetic right) moves bits toward the LSB and fills the vacated high positions with copies of the input's top bit. For example, 101001 by 2 gives 111010.
- R5: Operation codes 3'b100 (rotate left) and 3'b101 (rotate right) are circular and use the distance modulo N. For example, 101001 by 2 gives 100110 to the left and 011010 to the right.
- R6: At a distance of N or more, both logical shifts give all zeros. The arithmetic left shift gives N copies of bit 0, and the arithmetic right shift gives N copies of the top bit.
- R7: A distance of zero returns the input word unchanged under every operation code.
- R8: Operation codes 3'b110 and 3'b111 return the input word unchanged at any distance.
- R9: With REGISTER_OUT=1, a result taken while `in_valid` is high appears on `data_out` one clock later with `out_valid` high. While `in_valid` is low, `out_valid` goes low on the next clock and `data_out` holds its last value.
- R10: With REGISTER_OUT=1, a synchronous active-high `rst` clears `data_out` to zero and `out_valid` to 0 at the next clock edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; marks a word to be taken |
| data_in | input | WIDTH | Word to shift or rotate |
| amount | input | AMT_W | Unsigned shift distance |
| op | input | 3 | Operation code (see R1 to R5 and R8) |
| data_out | output | WIDTH | Shifted or rotated word |
| out_valid | output | 1 | Result strobe |

## Verification
On every cycle, the assertions check the timing of the valid strobe, the reset clear, and the hold of the output while no input is presented. They also check that zero distances and the spare operation codes leave the word unchanged, that a rotation keeps the number of set bits, and that logical shifts at or beyond the width give zero. The exact bit placement and fill value of each mode is shown only by the bench scenarios. These compare every distance from 0 to N+2 on all-zero, all-one, single-bit and random words against an independent per-bit model, and include the fixed 101001 examples.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
  parameter int WIDTH        = 6,
  parameter int AMT_W        = 4,
  parameter bit REGISTER_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] data_in,
  input  logic [AMT_W-1:0] amount,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] data_out,
  output logic             out_valid
);

  typedef enum logic [2:0] {
    OP_LSL = 3'b000,
    OP_LSR = 3'b001,
    OP_ASL = 3'b010,
    OP_ASR = 3'b011,
    OP_ROL = 3'b100,
    OP_ROR = 3'b101
  } op_e;

  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  logic [AMT_W-1:0] rot;
  logic [WIDTH-1:0] low_fill;
  logic [WIDTH-1:0] result;

  // Shifts by WIDTH or more give zero in SystemVerilog, so no separate saturation path is needed.
  assign rot      = AMT_W'(32'(amount) % WIDTH);
  assign low_fill = ~(ONES << amount);

  always_comb begin
    case (op)
      OP_LSL:  result = data_in << amount;
      OP_LSR:  result = data_in >> amount;
      OP_ASL:  result = (data_in << amount) | (data_in[0] ? low_fill : '0);
      OP_ASR:  result = WIDTH'($signed(data_in) >>> amount);
      OP_ROL:  result = (data_in << rot) | (data_in >> (WIDTH - int'(rot)));
      OP_ROR:  result = (data_in >> rot) | (data_in << (WIDTH - int'(rot)));
      default: result = data_in;
    endcase
  end

  generate
    if (REGISTER_OUT) begin : g_reg
      logic [WIDTH-1:0] q;
      logic             v;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
          v <= 1'b0;
        end else begin
          v <= in_valid;
          if (in_valid) q <= result;
        end
      end
      assign data_out  = q;
      assign out_valid = v;
    end else begin : g_comb
      assign data_out  = result;
      assign out_valid = in_valid;
    end
  endgenerate

endmodule

// File: rtl/shift_rotate_unit_chk.sv
module shift_rotate_unit_chk #(
  parameter int WIDTH        = 6,
  parameter int AMT_W        = 4,
  parameter bit REGISTER_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [WIDTH-1:0] data_in,
  input logic [AMT_W-1:0] amount,
  input logic [2:0]       op,
  input logic [WIDTH-1:0] data_out,
  input logic             out_valid
);

  logic is_rot, is_pass, is_lbig;
  assign is_rot  = (op == 3'b100) || (op == 3'b101);
  assign is_pass = (op == 3'b110) || (op == 3'b111);
  assign is_lbig = ((op == 3'b000) || (op == 3'b001)) && (32'(amount) >= WIDTH);

  generate
    if (REGISTER_OUT) begin : g_reg
      AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && data_out == '0)); // R10
      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R9
      AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(data_out))); // R9
      AST_ZERO_AMOUNT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && amount == '0) |=> data_out == $past(data_in)); // R7
      AST_SPARE_CODES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_pass) |=> data_out == $past(data_in)); // R8
      AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_rot) |=> $countones(data_out) == $countones($past(data_in))); // R5
      AST_LOGICAL_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_lbig) |=> data_out == '0); // R6
    end else begin : g_comb
      AST_VALID_FOLLOWS: assert property (@(posedge clk) out_valid == in_valid); // R9
      AST_ZERO_AMOUNT: assert property (@(posedge clk) (amount == '0) |-> data_out == data_in); // R7
      AST_SPARE_CODES: assert property (@(posedge clk) is_pass |-> data_out == data_in); // R8
      AST_ROT_KEEPS_ONES: assert property (@(posedge clk)
        is_rot |-> $countones(data_out) == $countones(data_in)); // R5
      AST_LOGICAL_FLUSH: assert property (@(posedge clk) is_lbig |-> data_out == '0); // R6
    end
  endgenerate

endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(
  .WIDTH(WIDTH), .AMT_W(AMT_W), .REGISTER_OUT(REGISTER_OUT)
) u_chk (.*);

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;
  localparam int W = 6;
  localparam int A = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [A-1:0] amount = '0;
  logic [2:0]   op = '0;
  logic [W-1:0] data_out;
  logic         out_valid;
  int           errors = 0;
  int           checks = 0;

  always #5 clk = ~clk;

  shift_rotate_unit #(.WIDTH(W), .AMT_W(A), .REGISTER_OUT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .data_in(data_in),
    .amount(amount), .op(op), .data_out(data_out), .out_valid(out_valid));

  function automatic logic [W-1:0] model(logic [W-1:0] d, int a, int o);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      case (o)
        0: r[i] = (i - a >= 0) ? d[i-a] : 1'b0;
        1: r[i] = (i + a < W) ? d[i+a] : 1'b0;
        2: r[i] = (i - a >= 0) ? d[i-a] : d[0];
        3: r[i] = (i + a < W) ? d[i+a] : d[W-1];
        4: r[i] = d[(i - (a % W) + W) % W];
        5: r[i] = d[(i + a) % W];
        default: r[i] = d[i];
      endcase
    end
    return r;
  endfunction

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic apply(logic [W-1:0] d, int a, int o);
    @(negedge clk);
    in_valid = 1'b1; data_in = d; amount = A'(a); op = 3'(o);
    @(negedge clk);
  endtask

  function automatic string tag(int a, int o);
    if (o >= 6) return "R8";
    if (a == 0) return "R7";
    if (a >= W && o < 4) return "R6";
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic t_reset_state();
    check("R10 valid in reset", W'(out_valid), '0);
    check("R10 data in reset", data_out, '0);
  endtask

  task automatic t_fixed_vectors();
    apply(6'b101001, 2, 0); check("R1 lsl", data_out, 6'b100100);
    check("R9 valid", W'(out_valid), W'(1));
    apply(6'b101001, 2, 1); check("R2 lsr", data_out, 6'b001010);
    apply(6'b101001, 2, 2); check("R3 asl", data_out, 6'b100111);
    apply(6'b101001, 2, 3); check("R4 asr", data_out, 6'b111010);
    apply(6'b101001, 2, 4); check("R5 rol", data_out, 6'b100110);
    apply(6'b101001, 2, 5); check("R5 ror", data_out, 6'b011010);
  endtask

  task automatic t_large_amount();
    apply(6'b101001, 15, 0); check("R6 lsl 15", data_out, 6'b000000);
    apply(6'b101001, 15, 1); check("R6 lsr 15", data_out, 6'b000000);
    apply(6'b101001, 15, 2); check("R6 asl 15", data_out, 6'b111111);
    apply(6'b101001, 15, 3); check("R6 asr 15", data_out, 6'b111111);
    apply(6'b010110, 15, 2); check("R6 asl 15 zero", data_out, 6'b000000);
    apply(6'b010110, 15, 3); check("R6 asr 15 zero", data_out, 6'b000000);
    apply(6'b101001, 15, 4); check("R5 rol 15", data_out, 6'b001101);
    apply(6'b101001, 6, 5);  check("R5 ror 6", data_out, 6'b101001);
  endtask

  task automatic t_spare_codes();
    for (int a = 0; a < 16; a += 5) begin
      apply(6'b110010, a, 6); check("R8 code 110", data_out, 6'b110010);
      apply(6'b011101, a, 7); check("R8 code 111", data_out, 6'b011101);
    end
  endtask

  task automatic t_sweep();
    logic [W-1:0] pats[12];
    pats[0] = '0;
    pats[1] = '1;
    for (int b = 0; b < W; b++) pats[2+b] = W'(1) << b;
    for (int k = 0; k < 4; k++) pats[2+W+k] = W'($urandom);
    for (int o = 0; o < 6; o++)
      for (int a = 0; a <= W + 2; a++)
        for (int p = 0; p < 12; p++) begin
          apply(pats[p], a, o);
          check(tag(a, o), data_out, model(pats[p], a, o));
        end
  endtask

  task automatic t_idle_hold();
    apply(6'b100011, 1, 4);
    @(negedge clk);
    in_valid = 1'b0; data_in = 6'b010101; op = 3'd0; amount = '0;
    @(negedge clk);
    check("R9 idle valid", W'(out_valid), '0);
    check("R9 idle hold", data_out, 6'b000111);
  endtask

  task automatic t_mid_reset();
    apply(6'b111111, 0, 0);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; data_in = 6'b101010;
    @(negedge clk);
    check("R10 data cleared", data_out, '0);
    check("R10 valid cleared", W'(out_valid), '0);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    t_fixed_vectors();
    t_large_amount();
    t_spare_codes();
    t_sweep();
    t_idle_hold();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule